// File: doc/BRIEF.md
# Counter Configuration Register Read Router

This block serves read requests aimed at one read-only configuration register belonging to a performance counter unit. Each request carries the five fields of a system register access encoding together with the requester's current privilege level (0 to 3). The block checks whether the encoding names its register. It then walks a priority chain of trap-control bits, and that chain depends on the current level. One clock later it reports exactly one outcome: the register value, a trap aimed at a higher privilege level, or an undefined-instruction indication.

The register value is fixed when the block is elaborated. It comes from two parameters: the total number of counters and the number of auxiliary counters. A request whose encoding does not match produces no outcome, so another decoder can claim it. When the counter feature is absent, a matching request is reported as undefined.

Top module: `cnt_cfg_read_router`

## Requirements
- R1: A request is claimed only when op0=2'b11, op1=3'b011, CRn=4'b1101, CRm=4'b0010 and op2=3'b001. For any other encoding, no outcome is raised in the following cycle.
- R2: When `feat_present` is 0, a matching request raises `undef_valid` only. No data and no trap are reported.
- R3: At level 0, if level 1 runs in 64-bit state and `user_en` is 0, the request traps. The target is level 2 when level 2 is enabled, runs in 64-bit state and `guest_redirect` is 1. In every other case the target is level 1.
- R4: At level 1, and at level 0 when R3 does not fire, the request traps to level 2 if level 2 is enabled, runs in 64-bit state and `el2_cnt_trap` is 1.
- R5: At levels 0, 1 and 2, if no earlier check fires, the request traps to level 3 when level 3 is present, runs in 64-bit state and `el3_cnt_trap` is 1.
- R6: At level 3 a matching request never traps. It always returns data.
- R7: Every trap reports `trap_class` = 6'h18.
- R8: The returned data has these fields: bits 7:0 hold the total counter count minus 1; bits 13:8 hold 63; bit 24 is 1; bits 31:28 hold 1 when any auxiliary counter exists and 0 otherwise. All other bits are 0.
- R9: A matching request raises exactly one of `rd_valid`, `trap_valid` or `undef_valid`, one clock after the request. The flag lasts a single cycle unless another request follows.
- R10: A synchronous active-low reset clears all outputs. The trap level code uses 1, 2 and 3 for levels 1, 2 and 3.
- R11: `trap_level` and `trap_class` change only in a cycle where `trap_valid` is asserted. They hold their values across reads and undefined outcomes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request pulse |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| cur_level | input | 2 | Current privilege level, 0 to 3 |
| el1_is64 | input | 1 | Level 1 runs in 64-bit state |
| el2_is64 | input | 1 | Level 2 runs in 64-bit state |
| el3_is64 | input | 1 | Level 3 runs in 64-bit state |
| el2_enabled | input | 1 | Level 2 is enabled |
| el3_present | input | 1 | Level 3 exists |
| feat_present | input | 1 | Counter feature implemented |
| user_en | input | 1 | Level 0 access enable |
| guest_redirect | input | 1 | Send level 0 traps to level 2 |
| el2_cnt_trap | input | 1 | Level 2 counter trap bit |
| el3_cnt_trap | input | 1 | Level 3 counter trap bit |
| rd_valid | output | 1 | Data returned |
| rd_data | output | 64 | Register value |
| trap_valid | output | 1 | Request trapped |
| trap_level | output | 2 | Trap target level |
| trap_class | output | 6 | Syndrome class |
| undef_valid | output | 1 | Undefined-instruction outcome |

## Verification
The bench targets each link of the priority chain and checks which one wins when several trap bits are set at once. A design with the order reversed would send a level 0 user-enable trap to level 3. A design that ignores the execution-state flags would trap even when a controlling level runs in 32-bit state. The bench also checks the guest redirect, which a faulty design would drop, leaving the target at level 1. It drives near-miss encodings that a loose decoder would claim, and it checks that reads and undefined outcomes leave the last trap level untouched.

// File: rtl/cnt_cfg_pkg.sv
// Package: shared level codes and the syndrome class used by the read router.
// Assumes privilege levels are numbered 0 (least) to 3 (most privileged).
package cnt_cfg_pkg;

    typedef enum logic [1:0] {
        LVL0 = 2'd0,
        LVL1 = 2'd1,
        LVL2 = 2'd2,
        LVL3 = 2'd3
    } lvl_e;

    localparam logic [5:0] TRAP_CLASS = 6'h18;

    localparam logic [1:0] ENC_OP0 = 2'b11;
    localparam logic [2:0] ENC_OP1 = 3'b011;
    localparam logic [3:0] ENC_CRN = 4'b1101;
    localparam logic [3:0] ENC_CRM = 4'b0010;
    localparam logic [2:0] ENC_OP2 = 3'b001;

endpackage

// File: rtl/cnt_cfg_word.sv
// Module: builds the 64-bit configuration value from elaboration parameters.
// Assumes 1 <= TOTAL_CNT <= 256 and AUX_CNT <= TOTAL_CNT (checked at elaboration).
module cnt_cfg_word #(
    parameter int TOTAL_CNT = 7,
    parameter int AUX_CNT   = 3,
    parameter int DATA_W    = 64
) (
    output logic [DATA_W-1:0] word
);
    localparam logic [7:0] N_FIELD   = 8'(TOTAL_CNT - 1);
    localparam logic [3:0] GRP_FIELD = (AUX_CNT > 0) ? 4'd1 : 4'd0;
    localparam logic [5:0] SZ_FIELD  = 6'd63;

    if (TOTAL_CNT < 1 || TOTAL_CNT > 256) begin : g_bad_total
        $error("TOTAL_CNT must lie in 1..256");
    end
    if (AUX_CNT < 0 || AUX_CNT > TOTAL_CNT) begin : g_bad_aux
        $error("AUX_CNT must lie in 0..TOTAL_CNT");
    end
    if (DATA_W != 64) begin : g_bad_width
        $error("DATA_W must be 64");
    end

    // Assemble the fields; unused bits read as zero.
    always_comb begin
        word        = '0;
        word[7:0]   = N_FIELD;
        word[13:8]  = SZ_FIELD;
        word[24]    = 1'b1;
        word[31:28] = GRP_FIELD;
    end
endmodule

// File: rtl/cnt_cfg_decode.sv
// Module: compares the access encoding against the one owned by this block.
// Assumes fields are valid whenever they are sampled; purely combinational.
module cnt_cfg_decode
    import cnt_cfg_pkg::*;
(
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit
);
    // Claim the request only when every field matches exactly.
    always_comb begin
        hit = (op0 == ENC_OP0) && (op1 == ENC_OP1) && (crn == ENC_CRN) &&
              (crm == ENC_CRM) && (op2 == ENC_OP2);
    end
endmodule

// File: rtl/cnt_cfg_trap_chain.sv
// Module: evaluates the level-dependent trap priority chain.
// Assumes the caller qualifies the result with a matching, implemented access.
module cnt_cfg_trap_chain
    import cnt_cfg_pkg::*;
(
    input  logic [1:0] level,
    input  logic       el1_is64,
    input  logic       el2_is64,
    input  logic       el3_is64,
    input  logic       el2_enabled,
    input  logic       el3_present,
    input  logic       user_en,
    input  logic       guest_redirect,
    input  logic       el2_cnt_trap,
    input  logic       el3_cnt_trap,
    output logic       do_trap,
    output logic [1:0] target
);
    logic el2_live;
    logic el3_live;
    logic user_hit;
    logic el2_hit;
    logic el3_hit;

    // Per-level trap conditions, before priority is applied.
    always_comb begin
        el2_live = el2_enabled && el2_is64;
        el3_live = el3_present && el3_is64;
        user_hit = el1_is64 && !user_en;
        el2_hit  = el2_live && el2_cnt_trap;
        el3_hit  = el3_live && el3_cnt_trap;
    end

    // Strict priority: user gate, then level 2 trap, then level 3 trap.
    always_comb begin
        do_trap = 1'b0;
        target  = LVL1;
        unique case (lvl_e'(level))
            LVL0: begin
                if (user_hit) begin
                    do_trap = 1'b1;
                    target  = (el2_live && guest_redirect) ? LVL2 : LVL1;
                end else if (el2_hit) begin
                    do_trap = 1'b1;
                    target  = LVL2;
                end else if (el3_hit) begin
                    do_trap = 1'b1;
                    target  = LVL3;
                end
            end
            LVL1: begin
                if (el2_hit) begin
                    do_trap = 1'b1;
                    target  = LVL2;
                end else if (el3_hit) begin
                    do_trap = 1'b1;
                    target  = LVL3;
                end
            end
            LVL2: begin
                if (el3_hit) begin
                    do_trap = 1'b1;
                    target  = LVL3;
                end
            end
            default: begin
                do_trap = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cnt_cfg_read_router.sv
// Module: top of the read router; registers one outcome per matching request.
// Assumes req_valid is a pulse and all control inputs are stable with it.
module cnt_cfg_read_router
    import cnt_cfg_pkg::*;
#(
    parameter int TOTAL_CNT = 7,
    parameter int AUX_CNT   = 3,
    parameter int DATA_W    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op0,
    input  logic [2:0]        req_op1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op2,
    input  logic [1:0]        cur_level,
    input  logic              el1_is64,
    input  logic              el2_is64,
    input  logic              el3_is64,
    input  logic              el2_enabled,
    input  logic              el3_present,
    input  logic              feat_present,
    input  logic              user_en,
    input  logic              guest_redirect,
    input  logic              el2_cnt_trap,
    input  logic              el3_cnt_trap,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              trap_valid,
    output logic [1:0]        trap_level,
    output logic [5:0]        trap_class,
    output logic              undef_valid
);
    logic              hit;
    logic              do_trap;
    logic [1:0]        target;
    logic [DATA_W-1:0] cfg_word;
    logic              claim;

    cnt_cfg_word #(
        .TOTAL_CNT (TOTAL_CNT),
        .AUX_CNT   (AUX_CNT),
        .DATA_W    (DATA_W)
    ) u_word (
        .word (cfg_word)
    );

    cnt_cfg_decode u_dec (
        .op0 (req_op0),
        .op1 (req_op1),
        .crn (req_crn),
        .crm (req_crm),
        .op2 (req_op2),
        .hit (hit)
    );

    cnt_cfg_trap_chain u_chain (
        .level          (cur_level),
        .el1_is64       (el1_is64),
        .el2_is64       (el2_is64),
        .el3_is64       (el3_is64),
        .el2_enabled    (el2_enabled),
        .el3_present    (el3_present),
        .user_en        (user_en),
        .guest_redirect (guest_redirect),
        .el2_cnt_trap   (el2_cnt_trap),
        .el3_cnt_trap   (el3_cnt_trap),
        .do_trap        (do_trap),
        .target         (target)
    );

    // A request is ours when it is valid and its encoding matches.
    always_comb begin
        claim = req_valid && hit;
    end

    // Register exactly one outcome; trap fields and data hold between uses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid    <= 1'b0;
            rd_data     <= '0;
            trap_valid  <= 1'b0;
            trap_level  <= 2'd0;
            trap_class  <= 6'd0;
            undef_valid <= 1'b0;
        end else begin
            rd_valid    <= claim && feat_present && !do_trap;
            trap_valid  <= claim && feat_present && do_trap;
            undef_valid <= claim && !feat_present;
            if (claim && feat_present && !do_trap) begin
                rd_data <= cfg_word;
            end
            if (claim && feat_present && do_trap) begin
                trap_level <= target;
                trap_class <= TRAP_CLASS;
            end
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, trap_valid, undef_valid})); // R9
    AST_CLASS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (trap_class == 6'h18)); // R7
    AST_NOMATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |=> !(rd_valid || trap_valid || undef_valid)); // R1
    AST_ABSENT_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && !feat_present) |=> undef_valid); // R2
    AST_TOP_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && feat_present && cur_level == 2'd3) |=> rd_valid); // R6
    AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |-> ($stable(trap_level) && $stable(trap_class))); // R11
    AST_DATA_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[63:32] == 32'd0 && rd_data[24] && rd_data[13:8] == 6'd63)); // R8
    AST_TARGET_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (trap_level != 2'd0)); // R10
endmodule

// File: tb/tb_cnt_cfg_read_router.sv
module tb_cnt_cfg_read_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op0 = 2'b11;
    logic [2:0]  req_op1 = 3'b011;
    logic [3:0]  req_crn = 4'b1101;
    logic [3:0]  req_crm = 4'b0010;
    logic [2:0]  req_op2 = 3'b001;
    logic [1:0]  cur_level = 2'd0;
    logic        el1_is64 = 1'b0, el2_is64 = 1'b0, el3_is64 = 1'b0;
    logic        el2_enabled = 1'b0, el3_present = 1'b0, feat_present = 1'b1;
    logic        user_en = 1'b1, guest_redirect = 1'b0;
    logic        el2_cnt_trap = 1'b0, el3_cnt_trap = 1'b0;
    logic        rd_valid, trap_valid, undef_valid;
    logic [63:0] rd_data;
    logic [1:0]  trap_level;
    logic [5:0]  trap_class;

    int checks = 0;
    int fails  = 0;

    // Default parameters: 7 counters, 3 auxiliary -> N=6, groups field=1.
    localparam logic [63:0] EXP_WORD = {32'd0, 4'd1, 3'd0, 1'b1, 10'd0, 6'd63, 8'd6};

    cnt_cfg_read_router dut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        el1_is64 = 0; el2_is64 = 0; el3_is64 = 0;
        el2_enabled = 0; el3_present = 0; feat_present = 1;
        user_en = 1; guest_redirect = 0; el2_cnt_trap = 0; el3_cnt_trap = 0;
        req_op0 = 2'b11; req_op1 = 3'b011; req_crn = 4'b1101;
        req_crm = 4'b0010; req_op2 = 3'b001;
    endtask

    // kind: 0 none, 1 data, 2 trap, 3 undefined
    task automatic send(input int kind, input logic [1:0] lvl, input string req);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " rd_valid"},    64'(rd_valid),    64'(kind == 1));
        chk({req, " trap_valid"},  64'(trap_valid),  64'(kind == 2));
        chk({req, " undef_valid"}, 64'(undef_valid), 64'(kind == 3));
        if (kind == 1) chk({req, " R8 data"}, rd_data, EXP_WORD);
        if (kind == 2) begin
            chk({req, " level"}, 64'(trap_level), 64'(lvl));
            chk({req, " R7 class"}, 64'(trap_class), 64'h18);
        end
        @(negedge clk);
        chk({req, " R9 pulse ends"}, 64'({rd_valid, trap_valid, undef_valid}), 64'd0);
    endtask

    task automatic t_reset();
        chk("R10 reset outputs", {rd_valid, trap_valid, undef_valid, trap_level, trap_class}, 64'd0);
        chk("R10 reset data", rd_data, 64'd0);
    endtask

    task automatic t_nomatch();
        idle_all(); cur_level = 2'd3;
        req_op2 = 3'b000;       send(0, 0, "R1 op2 miss");
        req_op2 = 3'b001; req_crm = 4'b0011; send(0, 0, "R1 crm miss");
        req_crm = 4'b0010; req_op1 = 3'b111; send(0, 0, "R1 op1 miss");
        idle_all(); send(1, 0, "R1 exact match");
    endtask

    task automatic t_absent();
        idle_all(); feat_present = 0; cur_level = 2'd0;
        el1_is64 = 1; user_en = 0;
        send(3, 0, "R2 feature absent");
    endtask

    task automatic t_user_gate();
        idle_all(); cur_level = 2'd0; el1_is64 = 1; user_en = 0;
        el2_enabled = 1; el2_is64 = 1; guest_redirect = 1;
        el3_present = 1; el3_is64 = 1; el3_cnt_trap = 1; el2_cnt_trap = 1;
        send(2, 2'd2, "R3 redirect to 2");
        guest_redirect = 0; send(2, 2'd1, "R3 to level 1");
        guest_redirect = 1; el2_is64 = 0; send(2, 2'd1, "R3 redirect needs 64-bit");
        idle_all(); cur_level = 2'd0; el1_is64 = 0; user_en = 0;
        send(1, 0, "R3 level 1 in 32-bit");
    endtask

    task automatic t_el2_trap();
        idle_all(); cur_level = 2'd0; el2_enabled = 1; el2_is64 = 1; el2_cnt_trap = 1;
        el3_present = 1; el3_is64 = 1; el3_cnt_trap = 1;
        send(2, 2'd2, "R4 from level 0");
        cur_level = 2'd1; send(2, 2'd2, "R4 from level 1");
        el2_enabled = 0; send(2, 2'd3, "R4 disabled falls to R5");
        el3_cnt_trap = 0; send(1, 0, "R4 no trap");
    endtask

    task automatic t_el3_trap();
        idle_all(); cur_level = 2'd2; el3_present = 1; el3_is64 = 1; el3_cnt_trap = 1;
        el2_enabled = 1; el2_is64 = 1; el2_cnt_trap = 1;
        send(2, 2'd3, "R5 from level 2");
        el3_is64 = 0; send(1, 0, "R5 32-bit no trap");
        el3_is64 = 1; el3_present = 0; send(1, 0, "R5 absent no trap");
    endtask

    task automatic t_top_level();
        idle_all(); cur_level = 2'd3; el1_is64 = 1; user_en = 0;
        el2_enabled = 1; el2_is64 = 1; el2_cnt_trap = 1;
        el3_present = 1; el3_is64 = 1; el3_cnt_trap = 1;
        send(1, 0, "R6 top level reads");
    endtask

    task automatic t_hold();
        idle_all(); cur_level = 2'd1; el2_enabled = 1; el2_is64 = 1; el2_cnt_trap = 1;
        send(2, 2'd2, "R11 setup trap");
        idle_all(); cur_level = 2'd3; send(1, 0, "R11 read after trap");
        chk("R11 level held after read", 64'(trap_level), 64'd2);
        feat_present = 0; send(3, 0, "R11 undef after trap");
        chk("R11 level held after undef", 64'(trap_level), 64'd2);
        chk("R11 class held", 64'(trap_class), 64'h18);
    endtask

    initial begin
        #2_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_nomatch();
        t_absent();
        t_user_gate();
        t_el2_trap();
        t_el3_trap();
        t_top_level();
        t_hold();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule